// File: doc/BRIEF.md
# Link Ability Arbitration Engine

This block listens to a qualified link-pulse strobe and turns each burst of pulses into a 16-bit ability word. Every burst has 17 timing pulses with 16 data positions between them. It then runs a two-phase agreement with the far end. In the first phase the partner's word must repeat unchanged. In the second phase the same word must come back with its acknowledge bit set. When both phases succeed, the engine picks the best 10 Mb/s duplex mode that both ends support.

The result appears on two outputs: a completion flag and a full-duplex flag. It is also packed into a status word, and the accepted partner word is shown on its own output. Any of five events makes the engine start again from a clean state:
- a restart request,
- a soft reset,
- the enable input rising,
- the link-fail input rising while enabled,
- the hardware reset.

All interval measurements count a 1 µs tick input.

Top module: `an_arbiter`

## Requirements
- R1: A burst starts with a timing pulse and holds 16 data positions, each closed by a further timing pulse. A pulse that arrives no more than 90 ticks after the last timing pulse is a data 1. A position with no such pulse is a 0. The first position received is bit 0 of the word.
- R2: Every pulse inside a burst must follow the previous pulse by 55 to 140 ticks. A pulse outside that window discards the burst in progress and opens a new burst itself, so the discarded burst yields no word.
- R3: Pulses of reversed polarity decode exactly like normal pulses. Status bit 5 shows the polarity flag of the burst that supplied the accepted partner word.
- R4: A word whose bits 4:0 are not 5'b00001 is discarded and does not count toward either phase.
- R5: Once three consecutive eligible words agree in every bit except bit 14, that word appears on `partnerWord` and status bit 3 is set.
- R6: After acceptance, three more eligible words that equal the partner word (bit 14 excepted) and have bit 14 set complete the negotiation, which sets `negDone` and status bit 0. A differing word during this phase sends the engine back to the first phase, and that word counts as the first repeat.
- R7: Full duplex is chosen when `advFull` is set and partner bit 6 is set; otherwise half duplex is chosen. The choice is shown on `modeFull`, status bit 1 (full) and status bit 2 (half), and is held while `negDone` is set.
- R8: Negotiation completes only if partner bit 5 (half duplex) is set and a common mode exists. Otherwise `negDone` stays 0 and status bit 4 is set.
- R9: Partner bit 15 has no effect on the selected mode.
- R10: A restart request, a soft reset, `enable` rising, `linkFail` rising while enabled, or the hardware reset clears the result, the partner word and status bits 5:0, and starts the first phase again.
- R11: While `enable` is low, the outputs stay cleared and incoming words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| tick | input | 1 | 1 µs timebase strobe |
| pulseStb | input | 1 | Qualified link pulse, one cycle |
| pulseNeg | input | 1 | Pulse was received with reversed polarity |
| enable | input | 1 | Negotiation enable |
| restartReq | input | 1 | Restart request strobe |
| softRst | input | 1 | Soft reset strobe |
| linkFail | input | 1 | Link-fail state indication |
| advFull | input | 1 | Local full-duplex ability |
| advHalf | input | 1 | Local half-duplex ability |
| negDone | output | 1 | Negotiation complete |
| modeFull | output | 1 | Selected mode is full duplex |
| statusWord | output | 16 | Bit 0 done, 1 full, 2 half, 3 partner accepted, 4 no common mode, 5 partner reversed polarity |
| partnerWord | output | 16 | Accepted partner ability word |

## Verification
A word leaves the decoder on the clock edge after its closing timing pulse is sampled. The acceptance and completion results follow one edge later, so they are due two edges after the final pulse. Restart events and enable changes act on the first edge that samples them. The bench therefore samples only after at least two falling edges have passed: it checks results after the 300-cycle gap it leaves between bursts, and checks restart effects two falling edges after the strobe.

// File: rtl/an_pkg.sv
package an_pkg;
  localparam int WORD_W = 16;
  localparam logic [4:0] SEL_CODE = 5'b00001;
  localparam int HD_BIT = 5;
  localparam int FD_BIT = 6;
  localparam int ACK_BIT = 14;
  // bit 14 (acknowledge) is left out of every word comparison
  localparam logic [WORD_W-1:0] MATCH_MASK = 16'hBFFF;

  typedef struct packed {
    logic clr;
    logic loadPartner;
    logic commit;
  } anStrobe_t;

  typedef enum logic [2:0] {
    ST_OFF, ST_DETECT, ST_ACK, ST_DONE, ST_FAIL
  } anState_t;
endpackage

// File: rtl/an_burst_rx.sv
module an_burst_rx #(
  parameter int GAP_MIN  = 55,
  parameter int GAP_MAX  = 140,
  parameter int DATA_LIM = 90,
  parameter int SLOTS    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             pulseStb,
  input  logic             pulseNeg,
  output logic             wordStb,
  output logic [SLOTS-1:0] word,
  output logic             wordNeg
);
  localparam int CW = $clog2(GAP_MAX + 2);
  localparam int SW = $clog2(SLOTS + 1);
  localparam logic [CW-1:0] CNT_SAT = CW'(GAP_MAX + 1);
  localparam logic [CW-1:0] MIN_C   = CW'(GAP_MIN);
  localparam logic [CW-1:0] MAX_C   = CW'(GAP_MAX);
  localparam logic [CW-1:0] DATA_C  = CW'(DATA_LIM);
  localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);

  logic [CW-1:0]    gapCnt, sinceClk;
  logic [SW-1:0]    slotCnt;
  logic [SLOTS-1:0] shiftReg;
  logic             inBurst, dataBit, burstNeg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gapCnt <= '0; sinceClk <= '0; slotCnt <= '0; shiftReg <= '0;
      inBurst <= 1'b0; dataBit <= 1'b0; burstNeg <= 1'b0;
      wordStb <= 1'b0; word <= '0; wordNeg <= 1'b0;
    end else begin
      wordStb <= 1'b0;
      if (tick && gapCnt != CNT_SAT) gapCnt <= gapCnt + 1'b1;
      if (tick && sinceClk != CNT_SAT) sinceClk <= sinceClk + 1'b1;
      if (pulseStb) begin
        gapCnt <= '0;
        if (!inBurst || gapCnt < MIN_C || gapCnt > MAX_C) begin
          // this pulse opens a fresh burst as its first timing pulse
          inBurst <= 1'b1; sinceClk <= '0; slotCnt <= '0;
          dataBit <= 1'b0; burstNeg <= pulseNeg;
        end else if (sinceClk <= DATA_C) begin
          dataBit <= 1'b1;
        end else begin
          sinceClk <= '0;
          dataBit  <= 1'b0;
          shiftReg <= {dataBit, shiftReg[SLOTS-1:1]};
          slotCnt  <= slotCnt + 1'b1;
          if (slotCnt == LAST_SLOT) begin
            inBurst <= 1'b0;
            wordStb <= 1'b1;
            word    <= {dataBit, shiftReg[SLOTS-1:1]};
            wordNeg <= burstNeg;
          end
        end
      end
    end
  end
endmodule

// File: rtl/an_datapath.sv
module an_datapath
  import an_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wordStb,
  input  logic [WORD_W-1:0] word,
  input  logic              wordNeg,
  input  logic              advFull,
  input  logic              advHalf,
  input  anStrobe_t         stb,
  output logic              eligible,
  output logic              sameLast,
  output logic              samePartner,
  output logic              ackSeen,
  output logic              commonOk,
  output logic [WORD_W-1:0] partnerWord,
  output logic              partnerNeg,
  output logic              negDone,
  output logic              modeFull,
  output logic              modeHalf
);
  logic [WORD_W-1:0] lastWord;
  logic              fullPick;

  assign eligible    = (word[4:0] == SEL_CODE);
  assign sameLast    = (((word ^ lastWord) & MATCH_MASK) == '0);
  assign samePartner = (((word ^ partnerWord) & MATCH_MASK) == '0);
  assign ackSeen     = word[ACK_BIT];
  assign fullPick    = advFull && partnerWord[FD_BIT];
  assign commonOk    = partnerWord[HD_BIT] && (fullPick || advHalf);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lastWord <= '0; partnerWord <= '0; partnerNeg <= 1'b0;
      negDone <= 1'b0; modeFull <= 1'b0; modeHalf <= 1'b0;
    end else begin
      if (wordStb && eligible) lastWord <= word;
      if (stb.clr) begin
        partnerWord <= '0; partnerNeg <= 1'b0;
        negDone <= 1'b0; modeFull <= 1'b0; modeHalf <= 1'b0;
      end else begin
        if (stb.loadPartner) begin
          partnerWord <= word;
          partnerNeg  <= wordNeg;
        end
        if (stb.commit) begin
          negDone  <= 1'b1;
          modeFull <= fullPick;
          modeHalf <= !fullPick;
        end
      end
    end
  end
endmodule

// File: rtl/an_control.sv
module an_control
  import an_pkg::*;
#(
  parameter int MATCH_CNT = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      restartReq,
  input  logic      softRst,
  input  logic      linkFail,
  input  logic      wordStb,
  input  logic      eligible,
  input  logic      sameLast,
  input  logic      samePartner,
  input  logic      ackSeen,
  input  logic      commonOk,
  output anStrobe_t stb,
  output logic      abilityMatched,
  output logic      noCommon
);
  localparam int CNTW = $clog2(MATCH_CNT + 1);
  localparam logic [CNTW-1:0] LAST = CNTW'(MATCH_CNT - 1);

  anState_t        state, stateN;
  logic [CNTW-1:0] cnt, cntN;
  logic            enableQ, linkFailQ, restartEv;

  assign restartEv = restartReq || softRst || (enable && !enableQ) ||
                     (enable && linkFail && !linkFailQ);

  always_comb begin
    stateN = state;
    cntN   = cnt;
    stb    = '0;
    if (!enable) begin
      stateN = ST_OFF; cntN = '0; stb.clr = 1'b1;
    end else if (restartEv) begin
      stateN = ST_DETECT; cntN = '0; stb.clr = 1'b1;
    end else if (wordStb && eligible) begin
      case (state)
        ST_DETECT: begin
          if (cnt != '0 && sameLast) begin
            if (cnt == LAST) begin
              stb.loadPartner = 1'b1; stateN = ST_ACK; cntN = '0;
            end else begin
              cntN = cnt + 1'b1;
            end
          end else begin
            cntN = CNTW'(1);
          end
        end
        ST_ACK: begin
          if (!samePartner) begin
            stateN = ST_DETECT; cntN = CNTW'(1);
          end else if (ackSeen) begin
            if (cnt == LAST) begin
              cntN = '0;
              if (commonOk) begin
                stb.commit = 1'b1; stateN = ST_DONE;
              end else begin
                stateN = ST_FAIL;
              end
            end else begin
              cntN = cnt + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_OFF; cnt <= '0; enableQ <= 1'b0; linkFailQ <= 1'b0;
    end else begin
      state     <= stateN;
      cnt       <= cntN;
      enableQ   <= enable;
      linkFailQ <= linkFail;
    end
  end

  assign abilityMatched = (state == ST_ACK) || (state == ST_DONE) || (state == ST_FAIL);
  assign noCommon       = (state == ST_FAIL);
endmodule

// File: rtl/an_arbiter.sv
module an_arbiter
  import an_pkg::*;
#(
  parameter int GAP_MIN   = 55,
  parameter int GAP_MAX   = 140,
  parameter int DATA_LIM  = 90,
  parameter int MATCH_CNT = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        pulseStb,
  input  logic        pulseNeg,
  input  logic        enable,
  input  logic        restartReq,
  input  logic        softRst,
  input  logic        linkFail,
  input  logic        advFull,
  input  logic        advHalf,
  output logic        negDone,
  output logic        modeFull,
  output logic [15:0] statusWord,
  output logic [15:0] partnerWord
);
  logic              wordStb, wordNeg, partnerNeg, modeHalf;
  logic [WORD_W-1:0] word;
  logic              eligible, sameLast, samePartner, ackSeen, commonOk;
  logic              abilityMatched, noCommon;
  anStrobe_t         stb;

  an_burst_rx #(.GAP_MIN(GAP_MIN), .GAP_MAX(GAP_MAX), .DATA_LIM(DATA_LIM), .SLOTS(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pulseStb(pulseStb), .pulseNeg(pulseNeg),
    .wordStb(wordStb), .word(word), .wordNeg(wordNeg));

  an_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .wordStb(wordStb), .word(word), .wordNeg(wordNeg),
    .advFull(advFull), .advHalf(advHalf), .stb(stb), .eligible(eligible),
    .sameLast(sameLast), .samePartner(samePartner), .ackSeen(ackSeen),
    .commonOk(commonOk), .partnerWord(partnerWord), .partnerNeg(partnerNeg),
    .negDone(negDone), .modeFull(modeFull), .modeHalf(modeHalf));

  an_control #(.MATCH_CNT(MATCH_CNT)) u_ctl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .restartReq(restartReq),
    .softRst(softRst), .linkFail(linkFail), .wordStb(wordStb), .eligible(eligible),
    .sameLast(sameLast), .samePartner(samePartner), .ackSeen(ackSeen),
    .commonOk(commonOk), .stb(stb), .abilityMatched(abilityMatched),
    .noCommon(noCommon));

  assign statusWord = {10'b0, partnerNeg, noCommon, abilityMatched, modeHalf, modeFull, negDone};
endmodule

// File: rtl/an_arbiter_chk.sv
module an_arbiter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        enable,
  input logic        restartReq,
  input logic        softRst,
  input logic        negDone,
  input logic        modeFull,
  input logic [15:0] statusWord,
  input logic [15:0] partnerWord
);
  AST_FULL_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    modeFull |-> negDone); // R7
  AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    negDone |-> ($countones(statusWord[2:1]) == 1)); // R7
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (negDone && $past(negDone)) |-> $stable(modeFull)); // R7
  AST_PARTNER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    negDone |-> partnerWord[5]); // R8
  AST_FAIL_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    statusWord[4] |-> !negDone); // R8
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (restartReq || softRst) |=> (!negDone && !statusWord[3])); // R10
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (statusWord[5:0] == 6'd0 && partnerWord == 16'd0)); // R11
endmodule

bind an_arbiter an_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .restartReq(restartReq),
  .softRst(softRst), .negDone(negDone), .modeFull(modeFull),
  .statusWord(statusWord), .partnerWord(partnerWord));

// File: tb/an_arbiter_bench.sv
module an_arbiter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic pulseStb = 1'b0, pulseNeg = 1'b0;
  logic enable = 1'b1, restartReq = 1'b0, softRst = 1'b0, linkFail = 1'b0;
  logic advFull = 1'b1, advHalf = 1'b1;
  logic negDone, modeFull;
  logic [15:0] statusWord, partnerWord;
  int nChecks = 0, nFail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  an_arbiter u_an_arbiter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pulseStb(pulseStb), .pulseNeg(pulseNeg),
    .enable(enable), .restartReq(restartReq), .softRst(softRst), .linkFail(linkFail),
    .advFull(advFull), .advHalf(advHalf), .negDone(negDone), .modeFull(modeFull),
    .statusWord(statusWord), .partnerWord(partnerWord));

  // {neg, advFull, advHalf, word[15:0], expDone, expFull}
  localparam logic [20:0] VECS [0:5] = '{
    {1'b0, 1'b1, 1'b1, 16'h0061, 1'b1, 1'b1},
    {1'b0, 1'b1, 1'b1, 16'h00A1, 1'b1, 1'b0},
    {1'b0, 1'b0, 1'b1, 16'h0E61, 1'b1, 1'b0},
    {1'b0, 1'b1, 1'b1, 16'h0041, 1'b0, 1'b0},
    {1'b0, 1'b1, 1'b0, 16'h0021, 1'b0, 1'b0},
    {1'b1, 1'b1, 1'b1, 16'h8061, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic neg);
    pulseStb = 1'b1; pulseNeg = neg;
    @(negedge clk);
    pulseStb = 1'b0; pulseNeg = 1'b0;
  endtask

  // bad: 0 none, 1 short gap at slot 8, 2 long gap at slot 8
  task automatic sendWord(input logic [15:0] w, input logic neg, input int bad);
    pulse(neg);
    for (int i = 0; i < 16; i++) begin
      if (i == 8 && bad != 0) begin
        waitCyc((bad == 1 ? 40 : 200) - 1);
        pulse(neg);
      end else if (w[i]) begin
        waitCyc(59); pulse(neg);
        waitCyc(59); pulse(neg);
      end else begin
        waitCyc(119); pulse(neg);
      end
    end
    waitCyc(300);
  endtask

  task automatic strobe(input int which);
    case (which)
      0: restartReq = 1'b1;
      default: softRst = 1'b1;
    endcase
    @(negedge clk);
    restartReq = 1'b0; softRst = 1'b0;
    waitCyc(2);
  endtask

  task automatic send3(input logic [15:0] w);
    for (int k = 0; k < 3; k++) sendWord(w, 1'b0, 0);
  endtask

  initial begin
    waitCyc(3);
    chk("R10 reset negDone", {31'd0, negDone}, 32'd0);
    chk("R10 reset status", {16'd0, statusWord}, 32'd0);
    rst_n = 1'b1;
    waitCyc(3);
    chk("R10 after reset partner", {16'd0, partnerWord}, 32'd0);
    chk("R10 after reset modeFull", {31'd0, modeFull}, 32'd0);

    // hardware reset with enable high starts detection
    send3(16'h0021);
    chk("R5 R10 hw reset start matched", {31'd0, statusWord[3]}, 32'd1);
    chk("R5 partner word", {16'd0, partnerWord}, 32'h0021);
    chk("R1 R7 not done yet", {31'd0, negDone}, 32'd0);

    strobe(0);
    chk("R10 restartReq clears status", {16'd0, statusWord}, 32'd0);
    chk("R10 restartReq clears partner", {16'd0, partnerWord}, 32'd0);

    send3(16'h0021);
    chk("R5 matched before softRst", {31'd0, statusWord[3]}, 32'd1);
    strobe(1);
    chk("R10 softRst clears status", {16'd0, statusWord}, 32'd0);

    send3(16'h0021);
    chk("R5 matched before linkFail", {31'd0, statusWord[3]}, 32'd1);
    linkFail = 1'b1; waitCyc(3);
    chk("R10 linkFail rise clears status", {16'd0, statusWord}, 32'd0);
    linkFail = 1'b0;

    send3(16'h0021);
    chk("R5 matched before disable", {31'd0, statusWord[3]}, 32'd1);
    enable = 1'b0; waitCyc(3);
    chk("R11 disable clears status", {16'd0, statusWord}, 32'd0);
    send3(16'h0021);
    chk("R11 words ignored while off status", {16'd0, statusWord}, 32'd0);
    chk("R11 words ignored while off partner", {16'd0, partnerWord}, 32'd0);
    enable = 1'b1; waitCyc(3);
    send3(16'h0021);
    chk("R10 enable rise restarts detection", {31'd0, statusWord[3]}, 32'd1);

    // table of negotiations
    for (int v = 0; v < 6; v++) begin
      logic [20:0] e;
      logic [15:0] w;
      logic expHalf;
      e = VECS[v];
      w = e[17:2];
      advFull = e[19]; advHalf = e[18];
      expHalf = e[1] & ~e[0];
      strobe(0);
      for (int k = 0; k < 3; k++) sendWord(w, e[20], 0);
      for (int k = 0; k < 3; k++) sendWord(w | 16'h4000, e[20], 0);
      chk("R1 R3 R5 partner word", {16'd0, partnerWord}, {16'd0, w});
      chk("R6 R8 negDone", {31'd0, negDone}, {31'd0, e[1]});
      chk("R7 R9 modeFull", {31'd0, modeFull}, {31'd0, e[0]});
      chk("R3 R7 R8 status", {16'd0, statusWord},
          {16'd0, 10'd0, e[20], ~e[1], 1'b1, expHalf, e[0], e[1]});
    end

    // gap violations and foreign selector
    advFull = 1'b1; advHalf = 1'b1;
    strobe(0);
    sendWord(16'h0021, 1'b0, 0);
    sendWord(16'h0021, 1'b0, 1);
    sendWord(16'h0021, 1'b0, 0);
    sendWord(16'h0022, 1'b0, 0);
    sendWord(16'h0021, 1'b0, 2);
    chk("R2 R4 bad bursts and selector not counted", {31'd0, statusWord[3]}, 32'd0);
    sendWord(16'h0021, 1'b0, 0);
    chk("R2 R4 third good word accepts", {31'd0, statusWord[3]}, 32'd1);
    chk("R2 partner after bad bursts", {16'd0, partnerWord}, 32'h0021);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nFail++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule